// File: doc/BRIEF.md
# Prefetch Pollution Filter

This block estimates how often a hardware prefetcher pushes useful demand data out of a cache. It keeps a single-bit table indexed by a hash of the block address. When a prefetch fill evicts a block, the victim's index is marked. When a later prefetch fill arrives for an address that maps to a marked index, the mark is removed. Each demand miss looks up its own index. A marked index means that the miss was probably caused by an earlier prefetch eviction.

The table is approximate. Distinct addresses that share an index alias on purpose, and that aliasing is the price of not storing tags. Two saturating counters accumulate the number of demand misses and the number of them that were judged pollution-induced. A feedback controller reads both counters at the end of each interval and then zeroes them with a synchronous clear. The cache, its replacement logic and the controller are outside this block.

Top module: `pfp_pollution_filter`

## Requirements
- R1: After reset every table bit is zero, both counters read zero and `hit_valid` is low.
- R2: The table index of an address is its bits [11:0] XOR its bits [23:12]. Bits above 23 do not affect the index, so two addresses with equal folded index alias.
- R3: An eviction with `evict_by_pf` high sets the bit at the victim's index. An eviction with `evict_by_pf` low changes nothing.
- R4: A prefetch fill clears the bit at its address's index.
- R5: If a set and a clear hit the same index in the same cycle, the bit ends up clear.
- R6: A demand miss in cycle t gives `hit_valid` high in cycle t+1, and only then. In that cycle `hit_polluted` equals the indexed bit as it stood before the updates of cycle t.
- R7: Every demand miss adds one to `demand_total`.
- R8: A demand miss whose indexed bit is set also adds one to `pollution_total`.
- R9: Both counters stop at all-ones and never wrap.
- R10: `cnt_clear` zeroes both counters on the next edge and takes priority over a same-cycle increment. It leaves the table untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | An eviction happens this cycle |
| evict_addr | input | 32 | Block address of the victim |
| evict_by_pf | input | 1 | The evicting fill is a prefetch |
| pf_fill_valid | input | 1 | A prefetch fill is serviced this cycle |
| pf_fill_addr | input | 32 | Block address of the prefetch fill |
| dm_valid | input | 1 | A demand miss occurs this cycle |
| dm_addr | input | 32 | Block address of the demand miss |
| cnt_clear | input | 1 | Interval reset for both counters |
| hit_valid | output | 1 | Lookup result valid (one cycle after a demand miss) |
| hit_polluted | output | 1 | The demand miss is attributed to prefetch pollution |
| pollution_total | output | 16 | Saturating count of polluted demand misses |
| demand_total | output | 16 | Saturating count of demand misses |

## Verification
The assertions assume at most one demand miss per cycle. They also assume that `cnt_clear` and a demand miss are independent strobes that may coincide, and that the address buses carry any value. The assertions do not depend on which addresses alias. The random stimulus masks addresses down to a handful of bits in both fold halves, so that sets, clears and lookups keep colliding on a few indices. It also fires `cnt_clear` only rarely, so that the counters build up between clears. A long directed run of demand misses drives both counters into saturation.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
   typedef enum logic {
      HASH_LOW  = 1'b0,
      HASH_FOLD = 1'b1
   } hash_e;
endpackage

// File: rtl/pfp_index_hash.sv
module pfp_index_hash #(
   parameter int unsigned     ADDR_W = 32,
   parameter int unsigned     IDX_W  = 12,
   parameter pfp_pkg::hash_e  HASH   = pfp_pkg::HASH_FOLD
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   if (HASH == pfp_pkg::HASH_FOLD) begin : g_fold
      if (ADDR_W < 2*IDX_W) begin : g_bad
         $error("fold hash needs ADDR_W >= 2*IDX_W");
      end
      localparam int unsigned TOP = 2*IDX_W;
      assign idx = addr[IDX_W-1:0] ^ addr[TOP-1:IDX_W];
      if (ADDR_W > TOP) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:TOP];
      end
   end else begin : g_low
      if (ADDR_W < IDX_W) begin : g_bad
         $error("ADDR_W must cover IDX_W");
      end
      assign idx = addr[IDX_W-1:0];
      if (ADDR_W > IDX_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:IDX_W];
      end
   end
endmodule

// File: rtl/pfp_bit_table.sv
module pfp_bit_table #(
   parameter int unsigned IDX_W = 12,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);
   logic [DEPTH-1:0] bits_q;

   assign rd_bit = bits_q[rd_idx];

   // clear is applied last so it wins on a shared index
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else begin
         if (set_en) bits_q[set_idx] <= 1'b1;
         if (clr_en) bits_q[clr_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/pfp_sat_counter.sv
module pfp_sat_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   if (CNT_W < 2) begin : g_bad
      $error("CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                  count <= '0;
      else if (inc && count != MAXV)      count <= count + 1'b1;
   end
endmodule

// File: rtl/pfp_pollution_filter.sv
module pfp_pollution_filter #(
   parameter int unsigned    ADDR_W = 32,
   parameter int unsigned    IDX_W  = 12,
   parameter int unsigned    CNT_W  = 16,
   parameter pfp_pkg::hash_e HASH   = pfp_pkg::HASH_FOLD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              evict_by_pf,
   input  logic              pf_fill_valid,
   input  logic [ADDR_W-1:0] pf_fill_addr,
   input  logic              dm_valid,
   input  logic [ADDR_W-1:0] dm_addr,
   input  logic              cnt_clear,
   output logic              hit_valid,
   output logic              hit_polluted,
   output logic [CNT_W-1:0]  pollution_total,
   output logic [CNT_W-1:0]  demand_total
);
   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("IDX_W out of range");
   end

   logic [IDX_W-1:0] ev_idx, pf_idx, dm_idx;
   logic             dm_bit;

   pfp_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH(HASH)) u_hash_ev (
      .addr(evict_addr), .idx(ev_idx));
   pfp_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH(HASH)) u_hash_pf (
      .addr(pf_fill_addr), .idx(pf_idx));
   pfp_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH(HASH)) u_hash_dm (
      .addr(dm_addr), .idx(dm_idx));

   pfp_bit_table #(.IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .set_en(evict_valid && evict_by_pf), .set_idx(ev_idx),
      .clr_en(pf_fill_valid), .clr_idx(pf_idx),
      .rd_idx(dm_idx), .rd_bit(dm_bit));

   pfp_sat_counter #(.CNT_W(CNT_W)) u_cnt_dm (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(dm_valid),
      .count(demand_total));
   pfp_sat_counter #(.CNT_W(CNT_W)) u_cnt_pol (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(dm_valid && dm_bit),
      .count(pollution_total));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid    <= 1'b0;
         hit_polluted <= 1'b0;
      end else begin
         hit_valid    <= dm_valid;
         hit_polluted <= dm_valid && dm_bit;
      end
   end
endmodule

// File: rtl/pfp_pollution_checker.sv
module pfp_pollution_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dm_valid,
   input logic             cnt_clear,
   input logic             hit_valid,
   input logic             hit_polluted,
   input logic [CNT_W-1:0] pollution_total,
   input logic [CNT_W-1:0] demand_total
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   a_r6_result_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
      dm_valid |=> hit_valid);
   a_r6_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
      !dm_valid |=> !hit_valid && !hit_polluted);
   a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear |=> demand_total == '0 && pollution_total == '0);
   a_r7_demand_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_valid && !cnt_clear && demand_total != MAXV)
         |=> demand_total == $past(demand_total) + 1'b1);
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (demand_total == MAXV && !cnt_clear) |=> demand_total == MAXV);
   a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pollution_total <= demand_total);
   a_r8_count_on_polluted: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clear && dm_valid && pollution_total != MAXV)
         |=> (pollution_total == $past(pollution_total) + 1'b1) == hit_polluted);
endmodule

bind pfp_pollution_filter pfp_pollution_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dm_valid(dm_valid), .cnt_clear(cnt_clear),
   .hit_valid(hit_valid), .hit_polluted(hit_polluted),
   .pollution_total(pollution_total), .demand_total(demand_total));

// File: tb/tb_pfp_pollution_filter.sv
module tb_pfp_pollution_filter;
   localparam int CLK_PERIOD = 10;
   localparam int MAXC = 65535;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evict_valid = 0, evict_by_pf = 0, pf_fill_valid = 0, dm_valid = 0, cnt_clear = 0;
   logic [31:0] evict_addr = 0, pf_fill_addr = 0, dm_addr = 0;
   logic hit_valid, hit_polluted;
   logic [15:0] pollution_total, demand_total;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 0;
   logic [4095:0] mdl = '0;
   int m_dm = 0, m_pol = 0;
   bit e_hv = 0, e_hp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfp_pollution_filter dut (
      .clk(clk), .rst_n(rst_n),
      .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_by_pf(evict_by_pf),
      .pf_fill_valid(pf_fill_valid), .pf_fill_addr(pf_fill_addr),
      .dm_valid(dm_valid), .dm_addr(dm_addr), .cnt_clear(cnt_clear),
      .hit_valid(hit_valid), .hit_polluted(hit_polluted),
      .pollution_total(pollution_total), .demand_total(demand_total));

   function automatic logic [11:0] fidx(input logic [31:0] a);
      return a[11:0] ^ a[23:12];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle, update the model, compare after the edge
   task automatic step(input bit ev, input logic [31:0] ea, input bit epf,
                       input bit pf, input logic [31:0] pa,
                       input bit dm, input logic [31:0] da, input bit clr,
                       input bit cmp);
      evict_valid = ev; evict_addr = ea; evict_by_pf = epf;
      pf_fill_valid = pf; pf_fill_addr = pa;
      dm_valid = dm; dm_addr = da; cnt_clear = clr;
      e_hv = dm;
      e_hp = dm && mdl[fidx(da)];
      if (clr) begin m_dm = 0; m_pol = 0; end
      else begin
         if (dm && m_dm < MAXC) m_dm++;
         if (e_hp && m_pol < MAXC) m_pol++;
      end
      if (ev && epf) mdl[fidx(ea)] = 1'b1;
      if (pf) mdl[fidx(pa)] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (cmp) begin
         chk(hit_valid == e_hv, "R6 hit_valid", int'(hit_valid), int'(e_hv));
         if (e_hv) chk(hit_polluted == e_hp, "R6/R8 hit_polluted", int'(hit_polluted), int'(e_hp));
         chk(demand_total == 16'(m_dm), "R7 demand_total", int'(demand_total), m_dm);
         chk(pollution_total == 16'(m_pol), "R8 pollution_total", int'(pollution_total), m_pol);
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
            finish_run();
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(hit_valid == 0, "R1 hit_valid", int'(hit_valid), 0);
      chk(demand_total == 0, "R1 demand_total", int'(demand_total), 0);
      chk(pollution_total == 0, "R1 pollution_total", int'(pollution_total), 0);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0123, 0, 1); // R1 table empty
      chk(hit_polluted == 0, "R1 table clear", int'(hit_polluted), 0);

      // R3: non-prefetch eviction has no effect
      step(1, 32'h0000_0040, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0040, 0, 1);
      chk(hit_polluted == 0, "R3 demand eviction ignored", int'(hit_polluted), 0);
      // R3: prefetch eviction marks
      step(1, 32'h0000_0040, 1, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0040, 0, 1);
      chk(hit_polluted == 1, "R3 prefetch eviction marks", int'(hit_polluted), 1);
      // R2: aliasing through the fold and upper bits
      step(0, 0, 0, 0, 0, 1, 32'h0004_0000, 0, 1);
      chk(hit_polluted == 1, "R2 fold alias", int'(hit_polluted), 1);
      step(0, 0, 0, 0, 0, 1, 32'hAB00_0040, 0, 1);
      chk(hit_polluted == 1, "R2 upper bits ignored", int'(hit_polluted), 1);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0041, 0, 1);
      chk(hit_polluted == 0, "R2 distinct index", int'(hit_polluted), 0);
      // R4: prefetch fill clears
      step(0, 0, 0, 1, 32'h0000_1041, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0040, 0, 1);
      chk(hit_polluted == 0, "R4 fill clears", int'(hit_polluted), 0);
      // R5: same-cycle set and clear, clear wins
      step(1, 32'h0000_0777, 1, 1, 32'h0000_0777, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0777, 0, 1);
      chk(hit_polluted == 0, "R5 clear wins", int'(hit_polluted), 0);
      // R6: lookup sees the bit before same-cycle set
      step(1, 32'h0000_0888, 1, 0, 0, 1, 32'h0000_0888, 0, 1);
      chk(hit_polluted == 0, "R6 old value seen", int'(hit_polluted), 0);
      idle();
      chk(hit_valid == 0, "R6 single pulse", int'(hit_valid), 0);
      // R10: clear beats increment, table kept
      step(0, 0, 0, 0, 0, 1, 32'h0000_0888, 1, 1);
      chk(demand_total == 0, "R10 clear wins", int'(demand_total), 0);
      step(0, 0, 0, 0, 0, 1, 32'h0000_0888, 0, 1);
      chk(hit_polluted == 1 && pollution_total == 1, "R10 table kept",
          int'(pollution_total), 1);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] msk = 32'h0000_3003;
         step($urandom % 3 == 0, $urandom & msk, $urandom % 2,
              $urandom % 4 == 0, $urandom & msk,
              $urandom % 2, $urandom & msk, $urandom % 200 == 0, 1);
      end

      // R9: saturation
      step(1, 32'h0000_0999, 1, 0, 0, 0, 0, 1, 1);
      for (int i = 0; i < MAXC + 5; i++)
         step(0, 0, 0, 0, 0, 1, 32'h0000_0999, 0, 0);
      @(negedge clk);
      chk(demand_total == 16'hFFFF, "R9 demand saturates", int'(demand_total), MAXC);
      chk(pollution_total == 16'hFFFF, "R9 pollution saturates", int'(pollution_total), MAXC);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      chk(demand_total == 0, "R10 clear after saturation", int'(demand_total), 0);
      finish_run();
   end
endmodule